// File: doc/BRIEF.md
# Memory-Card Slot Status and Identity Registers

This block is a small register window for a memory-card slot. It watches two slot pins, one for the write-protect switch and one for card presence. It shows the write-protect level as a live bit. A card arrival is held as a sticky event bit, and that bit drives an interrupt line. Software reads the status word to see both bits. It releases the event by writing a one to the event bit's position.

The window also returns two fixed words: an identification word and an address-decode word. It has a placeholder word for flash programming that always reads zero. Writes to the flash and decode words are accepted and have no effect. Both pins are asynchronous, so each passes through a flop chain before it reaches the status logic. The bus is word-indexed. Reads are combinational from the index. A write takes effect on the clock edge where select and write-enable are both high.

Top module: `card_slot_regs`

## Requirements
- R1: While reset is high and after it is released, the status word reads zero and `card_irq` is low until a pin changes.
- R2: Status bit 0 follows the `wp_pin` level with a latency of three clock edges (two synchroniser stages plus the status flop), in both directions.
- R3: Status bit 3 sets three clock edges after `card_pin` goes high, and stays set after `card_pin` goes low.
- R4: A write to index 2 with data bit 3 set clears status bit 3 at that edge, provided the synchronised card level is low; other data bits in that write, including bit 0, change nothing.
- R5: A write to index 2 with data bit 3 clear leaves status bit 3 unchanged.
- R6: `card_irq` equals status bit 3 at all times.
- R7: Index 0 reads 0x41034003, index 1 reads 0, and index 3 reads 0x00000011.
- R8: Writes to index 1 and index 3 change neither those read values nor the status word.
- R9: If a clear write and a high synchronised card level meet at the same edge, status bit 3 stays set.
- R10: Any index above 3 reads zero, and writes to such indices leave the status word unchanged.
- R11: Status word bits other than 0 and 3 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_idx | input | IDX_W | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx |
| wp_pin | input | 1 | Write-protect switch level, asynchronous |
| card_pin | input | 1 | Card-present level, asynchronous |
| card_irq | output | 1 | Card-arrival interrupt, high while the event is pending |

## Verification
The hardest case to reach is a clear write landing on the same edge as a high synchronised card level. The set must win there. The bench reaches it by keeping the card pin high through the synchroniser delay and then issuing the clear write. The bit must survive that write and also the later fall of the pin. Only a second clear, issued after the low level has propagated, may release it. The pin latency is checked on both sides: one edge early shows the old value, and the exact edge shows the new one.

// File: rtl/card_slot_pkg.sv
package card_slot_pkg;

    localparam int WORD_W = 32;
    localparam int WP_POS   = 0;
    localparam int CARD_POS = 3;

    localparam logic [WORD_W-1:0] IDENT_WORD  = 32'h4103_4003;
    localparam logic [WORD_W-1:0] DECODE_WORD = 32'h0000_0011;

    typedef enum logic [1:0] {
        IX_IDENT  = 2'd0,
        IX_FLASH  = 2'd1,
        IX_STATUS = 2'd2,
        IX_DECODE = 2'd3
    } reg_ix_e;

    typedef struct packed {
        logic card;
        logic wp;
    } slot_stat_t;

    typedef struct packed {
        logic card;
        logic wp;
    } slot_pins_t;

    function automatic logic [WORD_W-1:0] pack_status(slot_stat_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WP_POS]   = s.wp;
        w[CARD_POS] = s.card;
        return w;
    endfunction

endpackage

// File: rtl/card_slot_sync.sv
module card_slot_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/card_slot_status.sv
module card_slot_status
    import card_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_pins_t pins_s,
    input  logic       clr_card,
    output slot_stat_t stat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.wp   <= pins_s.wp;
            // a pending arrival outranks a simultaneous clear
            stat_q.card <= pins_s.card | (stat_q.card & ~clr_card);
        end
    end
endmodule

// File: rtl/card_slot_decode.sv
module card_slot_decode
    import card_slot_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [WORD_W-1:0] bus_wdata,
    input  slot_stat_t        stat_q,
    output logic              clr_card,
    output logic [WORD_W-1:0] rdata
);
    logic    in_window;
    reg_ix_e ix;

    assign in_window = ((bus_idx >> 2) == '0);
    assign ix        = reg_ix_e'(bus_idx[1:0]);

    always_comb begin
        rdata = '0;
        if (in_window) begin
            unique case (ix)
                IX_IDENT:  rdata = IDENT_WORD;
                IX_FLASH:  rdata = '0;
                IX_STATUS: rdata = pack_status(stat_q);
                IX_DECODE: rdata = DECODE_WORD;
                default:   rdata = '0;
            endcase
        end
    end

    assign clr_card = bus_sel && bus_we && in_window && (ix == IX_STATUS)
                      && bus_wdata[CARD_POS];
endmodule

// File: rtl/card_slot_regs.sv
module card_slot_regs
    import card_slot_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              wp_pin,
    input  logic              card_pin,
    output logic              card_irq
);
    localparam int PIN_W = $bits(slot_pins_t);

    slot_pins_t pins_raw;
    slot_pins_t pins_s;
    slot_stat_t stat_q;
    logic       clr_card;
    logic       wp_sync;
    logic       card_sync;
    logic       wp_bit;
    logic       card_bit;

    assign pins_raw.wp   = wp_pin;
    assign pins_raw.card = card_pin;

    card_slot_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    card_slot_status u_status (
        .clk      (clk),
        .rst      (rst),
        .pins_s   (pins_s),
        .clr_card (clr_card),
        .stat_q   (stat_q)
    );

    card_slot_decode #(.IDX_W(IDX_W)) u_decode (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .stat_q    (stat_q),
        .clr_card  (clr_card),
        .rdata     (bus_rdata)
    );

    assign wp_sync   = pins_s.wp;
    assign card_sync = pins_s.card;
    assign wp_bit    = stat_q.wp;
    assign card_bit  = stat_q.card;
    assign card_irq  = stat_q.card;
endmodule

// File: rtl/card_slot_regs_chk.sv
module card_slot_regs_chk
    import card_slot_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [IDX_W-1:0]  bus_idx,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              wp_sync,
    input logic              card_sync,
    input logic              wp_bit,
    input logic              card_irq
);
    logic clr_wr;
    assign clr_wr = bus_sel && bus_we && (bus_idx == IDX_W'(2)) && bus_wdata[CARD_POS];

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !card_irq);

    assert_wp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wp_bit == $past(wp_sync)));

    assert_card_sets_R3: assert property (@(posedge clk) disable iff (rst)
        card_sync |=> card_irq);

    assert_card_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (card_irq && !clr_wr) |=> card_irq);

    assert_card_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !card_sync) |=> !card_irq);

    assert_ident_word_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_idx == IDX_W'(0)) |-> (bus_rdata == IDENT_WORD));

    assert_outside_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_idx > IDX_W'(3)) |-> (bus_rdata == '0));

    assert_spare_bits_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_idx == IDX_W'(2)) |-> ((bus_rdata[WORD_W-1:4] == '0) && (bus_rdata[2:1] == '0)));
endmodule

bind card_slot_regs card_slot_regs_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wp_sync   (wp_sync),
    .card_sync (card_sync),
    .wp_bit    (wp_bit),
    .card_irq  (card_irq)
);

// File: tb/card_slot_regs_bench.sv
module card_slot_regs_bench;
    localparam int IDX_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [IDX_W-1:0]  bus_idx = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              wp_pin = 1'b0;
    logic              card_pin = 1'b0;
    logic              card_irq;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    card_slot_regs #(.IDX_W(IDX_W)) u_card_slot_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wp_pin(wp_pin), .card_pin(card_pin), .card_irq(card_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        bus_idx = IDX_W'(idx);
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_idx = IDX_W'(idx); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_wdata = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2, v);
        chk("R1 status in reset", v, 32'h0);
        chk("R1 irq in reset", {31'b0, card_irq}, 32'h0);
        @(negedge clk); rst = 0;
        settle(2);
        rd(2, v);
        chk("R1 status after reset", v, 32'h0);
    endtask

    task automatic t_constants;
        logic [31:0] v;
        rd(0, v); chk("R7 ident", v, 32'h4103_4003);
        rd(1, v); chk("R7 flash word", v, 32'h0);
        rd(3, v); chk("R7 decode", v, 32'h11);
        wr(1, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        rd(1, v); chk("R8 flash word after write", v, 32'h0);
        rd(3, v); chk("R8 decode after write", v, 32'h11);
        rd(2, v); chk("R8 status after writes", v, 32'h0);
    endtask

    task automatic t_wp;
        logic [31:0] v;
        @(negedge clk); wp_pin = 1;
        settle(2);
        rd(2, v); chk("R2 wp one edge early", v, 32'h0);
        settle(1);
        rd(2, v); chk("R2 wp rise", v, 32'h1);
        wr(2, 32'h0000_0001 ^ 32'hFFFF_FFF7);
        rd(2, v); chk("R4 other bits ignored", v, 32'h1);
        @(negedge clk); wp_pin = 0;
        settle(2);
        rd(2, v); chk("R2 wp fall early", v, 32'h1);
        settle(1);
        rd(2, v); chk("R2 wp fall", v, 32'h0);
    endtask

    task automatic t_card_basic;
        logic [31:0] v;
        @(negedge clk); card_pin = 1;
        settle(2);
        chk("R6 irq before latency", {31'b0, card_irq}, 32'h0);
        settle(1);
        rd(2, v); chk("R3 card set", v, 32'h8);
        chk("R6 irq high", {31'b0, card_irq}, 32'h1);
        @(negedge clk); card_pin = 0;
        settle(4);
        rd(2, v); chk("R3 sticky after pin low", v, 32'h8);
        wr(2, 32'hFFFF_FFF7);
        rd(2, v); chk("R5 write without bit3", v, 32'h8);
        wr(9, 32'hFFFF_FFFF);
        rd(2, v); chk("R10 outside write ignored", v, 32'h8);
        rd(9, v); chk("R10 outside read", v, 32'h0);
        rd(15, v); chk("R10 top index read", v, 32'h0);
        wr(2, 32'h0000_0008);
        rd(2, v); chk("R4 clear", v, 32'h0);
        chk("R6 irq low after clear", {31'b0, card_irq}, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        @(negedge clk); card_pin = 1; wp_pin = 1;
        settle(3);
        rd(2, v); chk("R11 both bits only", v, 32'h9);
        wr(2, 32'h0000_0008);
        rd(2, v); chk("R9 set beats clear", v, 32'h9);
        chk("R9 irq stays", {31'b0, card_irq}, 32'h1);
        @(negedge clk); card_pin = 0;
        settle(3);
        rd(2, v); chk("R3 sticky after contest", v, 32'h9);
        wr(2, 32'h0000_0008);
        rd(2, v); chk("R4 clear after pin low", v, 32'h1);
        chk("R6 irq released", {31'b0, card_irq}, 32'h0);
    endtask

    initial begin
        settle(3);
        t_reset();
        t_constants();
        t_wp();
        t_card_basic();
        t_set_wins();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule